// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block is the master side of a slave-serial configuration link. It loads a target FPGA on request. It pulls the target's active-low program line to clear configuration memory and watches the open-drain init status line for the clear handshake. After a programming latency it takes bitstream bytes from a valid/ready byte stream and shifts each one out, most significant bit first, on a divided configuration clock with a data line.

After the byte flagged as last, the sequencer keeps clocking all-ones filler bytes. It samples the target's done line before each filler byte, until done is seen high or a completion timeout expires. When the timeout expires, the level of the init line tells a checksum or device fault apart from a missing sync word or a truncated image. A build parameter removes the init line: fixed delays then stand in for the handshake waits, and any completion failure is reported as a plain timeout.

Every request ends in exactly one one-cycle pulse, either success or error with a 3-bit code. The sequencer then returns to idle and accepts a new start. Both status inputs pass through two-flop synchronizers before the control logic uses them.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is held and after it is released, prog_n_o is high, cclk_o is low, s_ready_o is low, and done_ok_o and err_o are low.
- R2: A start without the partial flag drives prog_n_o low. It stays low for at least PROG_MIN_CYC cycles and until the synchronized init line reads low, and is then released high.
- R3: No configuration clock edge occurs before the init line has returned high. If the done line is high once init has returned high, the request ends with error code 4 and no byte is clocked.
- R4: If init does not go low within INIT_TO_CYC cycles of program assertion, the request ends with error code 2 and prog_n_o high. If init does not return high within INIT_TO_CYC cycles of program release, the request ends with error code 3.
- R5: At least LATENCY_CYC cycles pass between init returning high and the first rising edge of cclk_o.
- R6: Each byte is sent most significant bit first, one bit per cclk_o high phase. Within a byte, rising edges are 2*CLK_HALF cycles apart. dout_o changes only while cclk_o is low, so it is stable across every high phase.
- R7: s_ready_o is high only in the load phase while the shifter is free. A byte transfers on a cycle where s_valid_i and s_ready_o are both high, and bytes reach the target in stream order whatever the gaps between them.
- R8: After the last stream byte, bytes of value 0xFF are sent one at a time, and done is sampled before each one. The request ends with success after the filler that follows the first high sample, so at least one filler is always sent.
- R9: If done is still low at a sample taken after DONE_TO_CYC cycles of filling, one more filler is sent. The request then ends with error code 5 when init reads low, or code 6 when init reads high.
- R10: A start with the partial flag set ends with error code 1 on the next cycle, and prog_n_o never goes low.
- R11: With HAS_INIT = 0, program is held for the larger of PROG_MIN_CYC and NOINIT_DLY_CYC, each init wait becomes a fixed NOINIT_DLY_CYC delay, and an expired completion timeout gives error code 7.
- R12: Each request produces exactly one one-cycle pulse on done_ok_o or err_o, never both at once. err_code_o is 0 except during an err_o pulse, and a new start is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a load (sampled in idle) |
| partial_i | input | 1 | Request is a partial reconfiguration (rejected) |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the last of the image |
| s_ready_o | output | 1 | Sequencer accepts the byte |
| prog_n_o | output | 1 | Active-low program line to target |
| init_n_i | input | 1 | Open-drain init status line from target (low = clearing) |
| done_i | input | 1 | Target done line |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Configuration data, changes while cclk_o is low |
| done_ok_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 3 | Error code, valid with err_o |

## Verification
The bench builds one instance with the init line present, CLK_HALF = 4, PROG_MIN_CYC = 8, INIT_TO_CYC = 200, LATENCY_CYC = 30 and DONE_TO_CYC = 400. These values let both handshake timeouts, the completion timeout with either init level, and several filler bytes all fall within a few hundred cycles, and the target model's 4-cycle clear reply forces the minimum program hold to govern. A second instance uses HAS_INIT = 0 with NOINIT_DLY_CYC = 20, which is longer than PROG_MIN_CYC, so the fixed-delay path and the generic timeout code are reached. Both instances share the short completion window.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the serial configuration sequencer.
// Assumes: error codes are visible on the err_code_o port and must stay fixed.
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_PARTIAL   = 3'd1,
        ERR_CLR_TO    = 3'd2,
        ERR_REL_TO    = 3'd3,
        ERR_DONE_HIGH = 3'd4,
        ERR_CRC       = 3'd5,
        ERR_NOSYNC    = 3'd6,
        ERR_TIMEOUT   = 3'd7
    } cfg_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_CLEAR,
        ST_CHKDONE,
        ST_LATENCY,
        ST_LOAD,
        ST_FILL,
        ST_FILL_WAIT,
        ST_DIAG
    } cfg_state_e;

endpackage

// File: rtl/cfg_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Assumes: each bit is a slow level; bits are not coherent with each other.
module cfg_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/cfg_timer.sv
// Saturating up-counter used for every wait and timeout of the sequencer.
// Assumes: the owner clears it on state entry; it stops at all-ones.
module cfg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [TW-1:0] cnt_o
);

    logic [TW-1:0] cnt_q;

    // Purpose: count cycles since the last clear, holding at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cfg_shifter.sv
// Byte serializer for the configuration clock and data pair.
// Loads one byte when ready_o is high, drives it MSB first. The clock idles
// low, each phase lasts CLK_HALF system cycles, data moves only on falling
// edges, and ready_o returns after the eighth falling edge.
// Assumes: CLK_HALF >= 1.
module cfg_shifter #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       ready_o,
    output logic       cclk_o,
    output logic       dout_o
);

    localparam int HW = $clog2(CLK_HALF) + 1;
    localparam logic [HW-1:0] PH_LAST = HW'(CLK_HALF - 1);

    logic [HW-1:0] ph_q;
    logic [7:0]    sh_q;
    logic [2:0]    bit_q;
    logic          busy_q;
    logic          cclk_q;

    // Purpose: phase timing, clock toggling and MSB-first shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            sh_q   <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            cclk_q <= 1'b0;
        end else if (!busy_q) begin
            if (load_i) begin
                sh_q   <= byte_i;
                bit_q  <= 3'd7;
                busy_q <= 1'b1;
                ph_q   <= '0;
                cclk_q <= 1'b0;
            end
        end else if (ph_q != PH_LAST) begin
            ph_q <= ph_q + 1'b1;
        end else begin
            ph_q   <= '0;
            cclk_q <= ~cclk_q;
            if (cclk_q) begin
                if (bit_q == 3'd0) begin
                    busy_q <= 1'b0;
                end else begin
                    bit_q <= bit_q - 1'b1;
                    sh_q  <= {sh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign ready_o = ~busy_q;
    assign cclk_o  = cclk_q;
    assign dout_o  = sh_q[7];

endmodule

// File: rtl/serial_cfg_loader.sv
// Serial configuration sequencer, top level.
// Runs clear handshake, done check, programming latency, byte load and
// filler clocking, then pulses success or an error code and returns idle.
// Assumes: all cycle limits are >= 1; init_n_i and done_i are asynchronous.
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HALF       = 2,
    parameter int PROG_MIN_CYC   = 50,
    parameter int INIT_TO_CYC    = 100_000_000,
    parameter int LATENCY_CYC    = 760_000,
    parameter int DONE_TO_CYC    = 10_000_000,
    parameter bit HAS_INIT       = 1'b1,
    parameter int NOINIT_DLY_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       prog_n_o,
    input  logic       init_n_i,
    input  logic       done_i,
    output logic       cclk_o,
    output logic       dout_o,
    output logic       done_ok_o,
    output logic       err_o,
    output logic [2:0] err_code_o
);

    localparam int HOLD_CYC = (PROG_MIN_CYC > NOINIT_DLY_CYC) ? PROG_MIN_CYC : NOINIT_DLY_CYC;
    localparam int M1 = (INIT_TO_CYC > LATENCY_CYC) ? INIT_TO_CYC : LATENCY_CYC;
    localparam int M2 = (DONE_TO_CYC > HOLD_CYC) ? DONE_TO_CYC : HOLD_CYC;
    localparam int MAXLIM = (M1 > M2) ? M1 : M2;
    localparam int TW = $clog2(MAXLIM + 1) + 1;

    localparam logic [TW-1:0] LIM_PMIN  = TW'(PROG_MIN_CYC - 1);
    localparam logic [TW-1:0] LIM_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LIM_INIT  = TW'(INIT_TO_CYC - 1);
    localparam logic [TW-1:0] LIM_NOINI = TW'(NOINIT_DLY_CYC - 1);
    localparam logic [TW-1:0] LIM_LAT   = TW'(LATENCY_CYC - 1);
    localparam logic [TW-1:0] LIM_DONE  = TW'(DONE_TO_CYC - 1);

    cfg_state_e    st_q, st_d;
    logic          prog_q, prog_d;
    logic          ok_q, fin_ok;
    logic          err_q, fin_err;
    cfg_err_e      code_q, fin_code;
    logic          seen_done_q, seen_exp_q;
    logic          smp_fill;
    logic [TW-1:0] tmr;
    logic          tmr_clr;
    logic          init_s, done_s;
    logic          sh_ready, sh_load;
    logic [7:0]    sh_byte;
    logic          accept;
    logic          in_idle;

    cfg_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_n_i}),
        .sync_o  ({done_s, init_s})
    );

    cfg_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    cfg_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .byte_i  (sh_byte),
        .ready_o (sh_ready),
        .cclk_o  (cclk_o),
        .dout_o  (dout_o)
    );

    assign in_idle   = (st_q == ST_IDLE);
    assign s_ready_o = (st_q == ST_LOAD) && sh_ready;
    assign accept    = s_ready_o && s_valid_i;
    assign smp_fill  = (st_q == ST_FILL) && sh_ready;
    assign sh_load   = accept || smp_fill;
    assign sh_byte   = (st_q == ST_FILL) ? 8'hFF : s_data_i;

    // Purpose: next-state, program line and result decisions.
    always_comb begin
        st_d     = st_q;
        prog_d   = prog_q;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        fin_code = ERR_NONE;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (partial_i) begin
                        fin_err  = 1'b1;
                        fin_code = ERR_PARTIAL;
                    end else begin
                        st_d   = ST_PROG;
                        prog_d = 1'b0;
                    end
                end
            end
            ST_PROG: begin
                if (HAS_INIT) begin
                    if (!init_s && tmr >= LIM_PMIN) begin
                        st_d   = ST_CLEAR;
                        prog_d = 1'b1;
                    end else if (tmr >= LIM_INIT) begin
                        st_d     = ST_IDLE;
                        prog_d   = 1'b1;
                        fin_err  = 1'b1;
                        fin_code = ERR_CLR_TO;
                    end
                end else if (tmr >= LIM_HOLD) begin
                    st_d   = ST_CLEAR;
                    prog_d = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (HAS_INIT) begin
                    if (init_s) begin
                        st_d = ST_CHKDONE;
                    end else if (tmr >= LIM_INIT) begin
                        st_d     = ST_IDLE;
                        fin_err  = 1'b1;
                        fin_code = ERR_REL_TO;
                    end
                end else if (tmr >= LIM_NOINI) begin
                    st_d = ST_CHKDONE;
                end
            end
            ST_CHKDONE: begin
                if (done_s) begin
                    st_d     = ST_IDLE;
                    fin_err  = 1'b1;
                    fin_code = ERR_DONE_HIGH;
                end else begin
                    st_d = ST_LATENCY;
                end
            end
            ST_LATENCY: begin
                if (tmr >= LIM_LAT) begin
                    st_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (accept && s_last_i) begin
                    st_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (sh_ready) begin
                    st_d = ST_FILL_WAIT;
                end
            end
            ST_FILL_WAIT: begin
                if (sh_ready) begin
                    if (seen_done_q) begin
                        st_d   = ST_IDLE;
                        fin_ok = 1'b1;
                    end else if (seen_exp_q) begin
                        st_d = ST_DIAG;
                    end else begin
                        st_d = ST_FILL;
                    end
                end
            end
            ST_DIAG: begin
                st_d    = ST_IDLE;
                fin_err = 1'b1;
                if (!HAS_INIT) begin
                    fin_code = ERR_TIMEOUT;
                end else if (init_s) begin
                    fin_code = ERR_NOSYNC;
                end else begin
                    fin_code = ERR_CRC;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Purpose: restart the timer on each state change, except within filling.
    always_comb begin
        tmr_clr = (st_d != st_q);
        if ((st_q == ST_FILL || st_q == ST_FILL_WAIT) &&
            (st_d == ST_FILL || st_d == ST_FILL_WAIT)) begin
            tmr_clr = 1'b0;
        end
    end

    // Purpose: state, program line and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            prog_q <= 1'b1;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else begin
            st_q   <= st_d;
            prog_q <= prog_d;
            ok_q   <= fin_ok;
            err_q  <= fin_err;
            code_q <= fin_code;
        end
    end

    // Purpose: latch done level and timeout state at each filler sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_done_q <= 1'b0;
            seen_exp_q  <= 1'b0;
        end else if (smp_fill) begin
            seen_done_q <= done_s;
            seen_exp_q  <= (tmr >= LIM_DONE);
        end
    end

    assign prog_n_o   = prog_q;
    assign done_ok_o  = ok_q;
    assign err_o      = err_q;
    assign err_code_o = code_q;

endmodule

// File: rtl/cfg_loader_chk.sv
// Protocol checker for serial_cfg_loader, attached by bind.
// Assumes: it sees the top's ports plus the internal idle flag.
module cfg_loader_chk #(
    parameter int PROG_MIN_CYC = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       partial_i,
    input logic       s_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       dout_o,
    input logic       done_ok_o,
    input logic       err_o,
    input logic [2:0] err_code_o,
    input logic       in_idle
);

    int unsigned low_cnt;

    // Purpose: count consecutive cycles with the program line low.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_n_o) begin
            low_cnt <= 0;
        end else begin
            low_cnt <= low_cnt + 1;
        end
    end

    a_r6_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(dout_o));

    a_r2_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_n_o) && !err_o) |-> (low_cnt >= PROG_MIN_CYC));

    a_r12_ok_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |=> !done_ok_o);

    a_r12_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r12_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && err_o));

    a_r12_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (err_code_o == 3'd0));

    a_r7_ready_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> prog_n_o);

    a_r10_partial_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && start_i && partial_i) |=> (err_o && err_code_o == 3'd1 && prog_n_o));

endmodule

bind serial_cfg_loader cfg_loader_chk #(.PROG_MIN_CYC(PROG_MIN_CYC)) u_chk (.*);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;

    localparam int HALF = 4;
    localparam int PMIN = 8;
    localparam int ITO  = 200;
    localparam int LAT  = 30;
    localparam int DTO  = 400;
    localparam int NDLY = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // main instance signals
    logic       start = 0, partial = 0, s_valid = 0, s_last = 0;
    logic [7:0] s_data = 0;
    logic       s_ready, prog_n, cclk, dout, done_ok, err;
    logic [2:0] err_code;
    logic       init_n = 1, done = 0;

    // no-init instance signals
    logic       start2 = 0, s_valid2 = 0, s_last2 = 0;
    logic [7:0] s_data2 = 8'h5A;
    logic       s_ready2, prog_n2, cclk2, dout2, done_ok2, err2;
    logic [2:0] err_code2;

    serial_cfg_loader #(
        .CLK_HALF(HALF), .PROG_MIN_CYC(PMIN), .INIT_TO_CYC(ITO), .LATENCY_CYC(LAT),
        .DONE_TO_CYC(DTO), .HAS_INIT(1'b1), .NOINIT_DLY_CYC(NDLY)
    ) i_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
        .prog_n_o(prog_n), .init_n_i(init_n), .done_i(done), .cclk_o(cclk), .dout_o(dout),
        .done_ok_o(done_ok), .err_o(err), .err_code_o(err_code)
    );

    serial_cfg_loader #(
        .CLK_HALF(HALF), .PROG_MIN_CYC(PMIN), .INIT_TO_CYC(ITO), .LATENCY_CYC(LAT),
        .DONE_TO_CYC(DTO), .HAS_INIT(1'b0), .NOINIT_DLY_CYC(NDLY)
    ) i_serial_cfg_loader_noinit (
        .clk(clk), .rst_n(rst_n), .start_i(start2), .partial_i(1'b0),
        .s_data_i(s_data2), .s_valid_i(s_valid2), .s_last_i(s_last2), .s_ready_o(s_ready2),
        .prog_n_o(prog_n2), .init_n_i(1'b1), .done_i(1'b0), .cclk_o(cclk2), .dout_o(dout2),
        .done_ok_o(done_ok2), .err_o(err2), .err_code_o(err_code2)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // target model configuration
    logic       m_assert_ok = 1, m_release_ok = 1, m_done_early = 0, m_crc = 0;
    int         m_done_after = 0;
    int         exp_len = 0;
    logic [7:0] exp_b [0:15];

    // target model observations
    int   pl = 0, rel = 0, rx = 0, fill = 0, bitc = 0, mism = 0, fill_bad = 0;
    int   viol = 0, per_bad = 0, last_rise = -1;
    int   t_init_rise = -1, t_first = -1;
    int   prog_run = 0, prog_run_last = 0;
    logic prog_low_seen = 0, loaded = 0, cclk_p = 0, dout_p = 0;
    logic [7:0] sh = 0;

    // result monitors
    int   ok_cnt = 0, err_cnt = 0, last_code = 0, dbl = 0, codebad = 0;
    logic pok = 0, perr = 0;
    int   err2_cnt = 0, last_code2 = 0, prog2_run = 0, prog2_last = 0;

    task automatic chk(input logic cond, input string req, input int act, input int expv);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Purpose: cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Purpose: behavioural target model plus result monitors, at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_ok) ok_cnt++;
            if (err) begin err_cnt++; last_code = err_code; end
            if ((done_ok && pok) || (err && perr)) dbl++;
            if (!err && err_code != 0) codebad++;
            pok = done_ok; perr = err;
            if (err2) begin err2_cnt++; last_code2 = err_code2; end
            if (!prog_n2) prog2_run++;
            else if (prog2_run != 0) begin prog2_last = prog2_run; prog2_run = 0; end
        end
        if (!prog_n) begin
            pl++; rel = 0; rx = 0; fill = 0; bitc = 0; loaded = 0; t_first = -1;
            prog_run++; prog_low_seen = 1;
            if (pl >= 4 && m_assert_ok) init_n = 0;
            done = m_done_early;
        end else begin
            if (prog_run != 0) begin prog_run_last = prog_run; prog_run = 0; end
            pl = 0;
            if (!init_n && !loaded) begin
                rel++;
                if (rel >= 6 && m_release_ok) begin init_n = 1; t_init_rise = cyc; end
            end
            if (cclk && !cclk_p) begin
                if (bitc != 0 && (cyc - last_rise) != 2*HALF) per_bad++;
                last_rise = cyc;
                sh = {sh[6:0], dout};
                if (t_first < 0) t_first = cyc;
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    if (rx < exp_len) begin
                        if (sh != exp_b[rx]) mism++;
                        rx++;
                        if (rx == exp_len) begin loaded = 1; if (m_crc) init_n = 0; end
                    end else begin
                        fill++;
                        if (sh != 8'hFF) fill_bad++;
                    end
                end
            end
            if (cclk && cclk_p && dout != dout_p) viol++;
            if (m_done_early) done = 1;
            else done = loaded && (fill >= m_done_after);
        end
        cclk_p = cclk; dout_p = dout;
    end

    task automatic run_case(input int len, output logic got_ok, output int got_code);
        int b_ok, b_err, guard;
        b_ok = ok_cnt; b_err = err_cnt;
        exp_len = len;
        for (int i = 0; i < len; i++) exp_b[i] = 8'($urandom);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < len; i++) begin
            int gap;
            gap = $urandom % 4;
            for (int g = 0; g < gap; g++) @(negedge clk);
            s_valid = 1; s_data = exp_b[i]; s_last = (i == len - 1);
            guard = 0;
            while (!s_ready && ok_cnt == b_ok && err_cnt == b_err && guard < 20000) begin
                @(negedge clk); guard++;
            end
            if (!s_ready) begin s_valid = 0; s_last = 0; break; end
            @(negedge clk);
            s_valid = 0; s_last = 0;
        end
        guard = 0;
        while (ok_cnt == b_ok && err_cnt == b_err && guard < 30000) begin
            @(negedge clk); guard++;
        end
        got_ok   = (ok_cnt != b_ok);
        got_code = (err_cnt != b_err) ? last_code : 0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int exp_diag(input logic crc_lvl);
        return crc_lvl ? 5 : 6;
    endfunction

    initial begin
        logic okr;
        int   code;
        void'($urandom(32'd7));
        repeat (5) @(negedge clk);
        // R1: reset state while held
        chk(prog_n == 1 && cclk == 0 && s_ready == 0 && done_ok == 0 && err == 0,
            "R1 reset outputs", {prog_n, cclk, s_ready, done_ok, err}, 5'b10000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(prog_n == 1 && cclk == 0 && s_ready == 0 && !done_ok && !err,
            "R1 after release", {prog_n, cclk, s_ready}, 3'b100);

        // R10: partial request rejected, pins untouched
        prog_low_seen = 0;
        begin
            int b_err;
            b_err = err_cnt;
            @(negedge clk); start = 1; partial = 1;
            @(negedge clk); start = 0; partial = 0;
            chk(err == 1 && err_code == 3'd1, "R10 partial code", err_code, 1);
            repeat (4) @(negedge clk);
            chk(prog_low_seen == 0 && err_cnt == b_err + 1, "R10 prog untouched", prog_low_seen, 0);
        end

        // R2 R3 R5 R6 R7 R8: nominal load
        m_done_after = 2;
        run_case(5, okr, code);
        chk(okr == 1, "R8 nominal success", code, 0);
        chk(mism == 0 && rx == 5, "R6 R7 bytes MSB first in order", rx, 5);
        chk(fill == 3 && fill_bad == 0, "R8 filler count", fill, 3);
        chk(prog_run_last >= PMIN, "R2 program hold", prog_run_last, PMIN);
        chk(t_first > t_init_rise, "R3 no clock before init high", t_first, t_init_rise + 1);
        chk(t_first - t_init_rise >= LAT, "R5 latency", t_first - t_init_rise, LAT);
        chk(viol == 0, "R6 data stable while clock high", viol, 0);
        chk(per_bad == 0, "R6 clock period", per_bad, 0);
        chk(s_ready == 0, "R7 ready low in idle", s_ready, 0);

        // R8: done already high before first filler sample
        m_done_after = 0;
        run_case(3, okr, code);
        chk(okr == 1 && fill == 1, "R8 at least one filler", fill, 1);

        // R7 R8 R12: random loads with random gaps
        for (int k = 0; k < 6; k++) begin
            int len, da;
            len = 1 + ($urandom % 6);
            da  = $urandom % 4;
            m_done_after = da;
            run_case(len, okr, code);
            chk(okr == 1 && mism == 0 && rx == len, "R7 random load", rx, len);
            chk(fill == da + 1 && fill_bad == 0, "R8 random fillers", fill, da + 1);
        end
        chk(dbl == 0 && codebad == 0, "R12 single pulses", dbl + codebad, 0);

        // R4: init never asserts
        m_assert_ok = 0;
        begin
            int t0;
            t0 = cyc;
            run_case(2, okr, code);
            chk(!okr && code == 2, "R4 clear timeout code", code, 2);
            chk(prog_n == 1, "R4 program released", prog_n, 1);
            chk(cyc - t0 >= ITO, "R4 clear timeout length", cyc - t0, ITO);
        end
        m_assert_ok = 1;

        // R4: init never released
        m_release_ok = 0;
        run_case(2, okr, code);
        chk(!okr && code == 3, "R4 release timeout code", code, 3);
        m_release_ok = 1;

        // R3: done high at the check
        m_done_early = 1;
        run_case(2, okr, code);
        chk(!okr && code == 4, "R3 done high code", code, 4);
        chk(rx == 0 && t_first < 0, "R3 no bytes clocked", rx, 0);
        m_done_early = 0;

        // R9: completion timeout, init high
        m_done_after = 1000; m_crc = 0;
        run_case(3, okr, code);
        chk(!okr && code == exp_diag(1'b0), "R9 missing sync code", code, 6);
        chk(fill >= (DTO / (16 * HALF)) + 1 && fill_bad == 0, "R9 fillers until timeout", fill, DTO / (16 * HALF) + 1);

        // R9: completion timeout, init low
        m_crc = 1;
        run_case(3, okr, code);
        chk(!okr && code == exp_diag(1'b1), "R9 crc code", code, 5);
        m_crc = 0; m_done_after = 0;

        // R12: recovers and loads again
        run_case(2, okr, code);
        chk(okr == 1 && rx == 2, "R12 new start after error", rx, 2);

        // R11: no-init build
        begin
            int guard;
            @(negedge clk); start2 = 1;
            @(negedge clk); start2 = 0;
            s_valid2 = 1; s_last2 = 1;
            guard = 0;
            while (!s_ready2 && guard < 20000) begin @(negedge clk); guard++; end
            @(negedge clk); s_valid2 = 0; s_last2 = 0;
            guard = 0;
            while (err2_cnt == 0 && guard < 30000) begin @(negedge clk); guard++; end
            chk(err2_cnt == 1 && last_code2 == 7, "R11 generic timeout code", last_code2, 7);
            chk(prog2_last >= NDLY, "R11 fixed program hold", prog2_last, NDLY);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule